// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block drives one full-duplex word exchange on a four-wire serial link as the master. A write to the transmit port while the engine is idle pulls the active-low select line low, produces a programmable number of serial clock edges, shifts the word out on the master-out line and collects the reply from the master-in line. Clock polarity, clock phase, bit order and word width (half or full data width, 8 or 16 bits by default) are static configuration inputs. They are held constant while a transfer is in flight.

In phase mode 0, the master samples the incoming line into a one-bit holding flop on every odd clock edge. It shifts that bit into the receive shift register on the following even edge, and the next outgoing bit is presented after each even edge except the last. In phase mode 1, the outgoing line advances on odd edges and the incoming line is sampled and shifted on even edges. The receive side is double buffered. The completed word reaches the parallel receive register only at the final edge, and a completion flag rises at the same moment. Software clears the flag by reading status and then reading the received word. A word that completes before the previous one was collected overwrites it and sets an overrun flag.

Top module: `spi_master_engine`

## Requirements
- R1: After reset, select is high, the serial clock sits at the polarity level, the done, overrun and busy outputs are 0, and the receive register holds 0.
- R2: A transmit write while idle drives select low on the next clock and raises busy. The first serial clock edge follows (cfgDiv+1) clocks later.
- R3: Serial clock edges are spaced exactly (cfgDiv+1) clocks apart. A transfer produces exactly 2n edges, where n is 16 when cfgWide=1 and 8 when cfgWide=0.
- R4: Select returns high (cfgDiv+1) clocks after the last edge, and the serial clock is left at its idle level.
- R5: With cfgCpha=0 and MSB-first order, the first outgoing bit is on the line when select falls. Incoming bits are sampled on odd edges and shifted on even edges, and both words are exchanged intact.
- R6: With cfgCpha=1, the outgoing line changes on odd edges and incoming bits are taken on even edges, and both words are exchanged intact.
- R7: With cfgLsbFirst=1, bit 0 of the transmit word is sent first and the first received bit lands in bit 0. With cfgLsbFirst=0, bit n-1 goes first in both directions.
- R8: With cfgWide=0, only txData[7:0] is sent and rxData[15:8] reads 0.
- R9: cfgCpol sets only the idle level of the serial clock (0 gives low, 1 gives high). The exchanged data is the same for both levels.
- R10: rxData keeps its previous value throughout a transfer. It takes the new word on the clock of the final edge, and the done flag rises on that same clock.
- R11: The done flag clears only when a receive read follows a status read taken while the flag was set. A receive read on its own leaves the flag set.
- R12: If a word completes while the done flag is still set, the new word replaces rxData and the overrun flag is set. The status-then-receive read sequence clears both flags.
- R13: A transmit write while busy is ignored. The word in flight is unchanged and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgCpol | input | 1 | Serial clock idle level |
| cfgCpha | input | 1 | Clock phase select (0: sample on odd edges, 1: sample on even edges) |
| cfgLsbFirst | input | 1 | 1 sends and receives least significant bit first |
| cfgWide | input | 1 | 1 selects DATA_W bits, 0 selects DATA_W/2 bits |
| cfgDiv | input | DIV_W | Serial clock half period minus one, in system clocks |
| txWrite | input | 1 | Transmit register write strobe; starts a transfer when idle |
| txData | input | DATA_W | Word to transmit |
| statusRead | input | 1 | Status read strobe (first step of the flag clear) |
| rxRead | input | 1 | Receive register read strobe (second step of the flag clear) |
| rxData | output | DATA_W | Parallel receive register |
| doneFlag | output | 1 | Transfer complete flag |
| overrunFlag | output | 1 | Unread word was overwritten |
| busy | output | 1 | Transfer in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Master data out |
| miso | input | 1 | Master data in |
| ssN | output | 1 | Active-low slave select |

## Verification
The bench builds the engine with DATA_W=16 and DIV_W=4. This size reaches both the 8-bit and the 16-bit word lengths, and it allows half periods from one clock (cfgDiv=0) up to several clocks. A behavioural slave in the bench follows the same phase, order and width settings, so every combination of polarity, phase, order and width is checked as a real exchange in both directions. Edge spacing, the lead and tail gaps, the moment of the receive update and the flag sequences are all measured at the ports.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  // Per-cycle commands from the sequencer to the shifting datapath.
  typedef struct packed {
    logic start;     // load transmit word, clear receive shifter
    logic capture;   // sample miso into the holding flop
    logic shiftRx;   // move one bit into the receive shifter
    logic rxFromPin; // shift source is miso directly rather than the holding flop
    logic shiftTx;   // advance to the next outgoing bit
    logic commit;    // copy the finished word to the parallel register
  } engStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } engState_t;

endpackage

// File: rtl/spi_eng_datapath.sv
module spi_eng_datapath
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  engStrobe_t        strobe,
  input  logic              cfgLsbFirst,
  input  logic              cfgWide,
  input  logic [DATA_W-1:0] txData,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] txSr;
  logic [DATA_W-1:0] rxSr;
  logic [DATA_W-1:0] rxReg;
  logic [DATA_W-1:0] rxShifted;
  logic [DATA_W-1:0] rxFinal;
  logic [DATA_W-1:0] widthMask;
  logic              holdBit;
  logic              rxBit;

  // Active-width mask: upper half enabled only in wide mode.
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i < HALF_W) begin : g_low
      assign widthMask[i] = 1'b1;
    end else begin : g_high
      assign widthMask[i] = cfgWide;
    end
  end

  // Outgoing bit comes from whichever end leads for the selected order and width.
  always_comb begin
    if (cfgLsbFirst) begin
      mosi = txSr[0];
    end else if (cfgWide) begin
      mosi = txSr[DATA_W-1];
    end else begin
      mosi = txSr[HALF_W-1];
    end
  end

  assign rxBit = strobe.rxFromPin ? miso : holdBit;

  // Insert point: LSB end for MSB-first, top of the active window for LSB-first.
  always_comb begin
    rxShifted = rxSr;
    if (cfgLsbFirst) begin
      rxShifted = rxSr >> 1;
      if (cfgWide) begin
        rxShifted[DATA_W-1] = rxBit;
      end else begin
        rxShifted[HALF_W-1] = rxBit;
      end
    end else begin
      rxShifted = {rxSr[DATA_W-2:0], rxBit};
    end
  end

  assign rxFinal = (strobe.shiftRx ? rxShifted : rxSr) & widthMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSr    <= '0;
      rxSr    <= '0;
      rxReg   <= '0;
      holdBit <= 1'b0;
    end else begin
      if (strobe.start) begin
        txSr <= txData & widthMask;
        rxSr <= '0;
      end else begin
        if (strobe.shiftTx) begin
          txSr <= cfgLsbFirst ? (txSr >> 1) : (txSr << 1);
        end
        if (strobe.shiftRx) begin
          rxSr <= rxShifted;
        end
      end
      if (strobe.capture) begin
        holdBit <= miso;
      end
      if (strobe.commit) begin
        rxReg <= rxFinal;
      end
    end
  end

  assign rxData = rxReg;

endmodule

// File: rtl/spi_eng_control.sv
module spi_eng_control
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgCpha,
  input  logic             cfgWide,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             txWrite,
  input  logic             statusRead,
  input  logic             rxRead,
  output engStrobe_t       strobe,
  output logic             sckToggle,
  output logic             ssN,
  output logic             busy,
  output logic             doneFlag,
  output logic             overrunFlag
);

  localparam int CNT_W = $clog2(2 * DATA_W + 1);
  localparam logic [CNT_W-1:0] EDGES_FULL = CNT_W'(2 * DATA_W);
  localparam logic [CNT_W-1:0] EDGES_HALF = CNT_W'(DATA_W);

  engState_t        state;
  logic [DIV_W-1:0] hCnt;
  logic [CNT_W-1:0] edgeCnt;
  logic [CNT_W-1:0] totalEdges;
  logic             tick;
  logic             fire;
  logic             oddEdge;
  logic             lastEdge;
  logic             clearArmed;

  assign totalEdges = cfgWide ? EDGES_FULL : EDGES_HALF;
  assign tick       = (state != ST_IDLE) && (hCnt >= cfgDiv);
  assign fire       = (state == ST_RUN) && tick;
  assign oddEdge    = ~edgeCnt[0];          // edge about to fire is edgeCnt+1
  assign lastEdge   = (edgeCnt + CNT_W'(1)) == totalEdges;

  always_comb begin
    strobe           = '0;
    strobe.start     = (state == ST_IDLE) && txWrite;
    strobe.capture   = fire && !cfgCpha && oddEdge;
    strobe.shiftRx   = fire && !oddEdge;
    strobe.rxFromPin = cfgCpha;
    strobe.shiftTx   = fire && ((!cfgCpha && !oddEdge && !lastEdge) ||
                                (cfgCpha && oddEdge && (edgeCnt != '0)));
    strobe.commit    = fire && lastEdge;
  end

  // Transfer sequencing: lead half period, 2n edges, tail half period.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      hCnt      <= '0;
      edgeCnt   <= '0;
      sckToggle <= 1'b0;
      ssN       <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (txWrite) begin
            state     <= ST_RUN;
            ssN       <= 1'b0;
            hCnt      <= '0;
            edgeCnt   <= '0;
            sckToggle <= 1'b0;
          end
        end
        ST_RUN: begin
          if (tick) begin
            hCnt      <= '0;
            sckToggle <= ~sckToggle;
            edgeCnt   <= edgeCnt + CNT_W'(1);
            if (lastEdge) begin
              state <= ST_TAIL;
            end
          end else begin
            hCnt <= hCnt + DIV_W'(1);
          end
        end
        ST_TAIL: begin
          if (tick) begin
            hCnt  <= '0;
            state <= ST_IDLE;
            ssN   <= 1'b1;
          end else begin
            hCnt <= hCnt + DIV_W'(1);
          end
        end
        default: begin
          state <= ST_IDLE;
          ssN   <= 1'b1;
        end
      endcase
    end
  end

  // Completion and overrun flags with a two-step clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag    <= 1'b0;
      overrunFlag <= 1'b0;
      clearArmed  <= 1'b0;
    end else if (strobe.commit) begin
      doneFlag   <= 1'b1;
      clearArmed <= 1'b0;
      if (doneFlag) begin
        overrunFlag <= 1'b1;
      end
    end else begin
      if (statusRead && doneFlag) begin
        clearArmed <= 1'b1;
      end
      if (rxRead && clearArmed) begin
        doneFlag    <= 1'b0;
        overrunFlag <= 1'b0;
        clearArmed  <= 1'b0;
      end
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgCpol,
  input  logic              cfgCpha,
  input  logic              cfgLsbFirst,
  input  logic              cfgWide,
  input  logic [DIV_W-1:0]  cfgDiv,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              statusRead,
  input  logic              rxRead,
  output logic [DATA_W-1:0] rxData,
  output logic              doneFlag,
  output logic              overrunFlag,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ssN
);

  engStrobe_t strobe;
  logic       sckToggle;

  spi_eng_control #(
    .DATA_W(DATA_W),
    .DIV_W (DIV_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgCpha    (cfgCpha),
    .cfgWide    (cfgWide),
    .cfgDiv     (cfgDiv),
    .txWrite    (txWrite),
    .statusRead (statusRead),
    .rxRead     (rxRead),
    .strobe     (strobe),
    .sckToggle  (sckToggle),
    .ssN        (ssN),
    .busy       (busy),
    .doneFlag   (doneFlag),
    .overrunFlag(overrunFlag)
  );

  spi_eng_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgLsbFirst(cfgLsbFirst),
    .cfgWide    (cfgWide),
    .txData     (txData),
    .miso       (miso),
    .mosi       (mosi),
    .rxData     (rxData)
  );

  // Polarity only flips the level; the edge sequence is polarity-free.
  assign sck = cfgCpol ^ sckToggle;

endmodule

// File: rtl/spi_master_engine_checker.sv
module spi_master_engine_checker #(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgCpol,
  input logic              cfgWide,
  input logic [DIV_W-1:0]  cfgDiv,
  input logic              rxRead,
  input logic [DATA_W-1:0] rxData,
  input logic              doneFlag,
  input logic              overrunFlag,
  input logic              busy,
  input logic              sck,
  input logic              ssN
);

  localparam int CNT_W = $clog2(2 * DATA_W + 1) + 1;
  localparam int GAP_W = DIV_W + 2;

  logic             prevSck;
  logic             prevSs;
  logic [CNT_W-1:0] edgeSeen;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSck  <= 1'b0;
      prevSs   <= 1'b1;
      edgeSeen <= '0;
      gap      <= '0;
    end else begin
      prevSck <= sck;
      prevSs  <= ssN;
      if (ssN) begin
        edgeSeen <= '0;
      end else if (sck != prevSck) begin
        edgeSeen <= edgeSeen + CNT_W'(1);
      end
      if ((prevSs && !ssN) || (sck != prevSck)) begin
        gap <= GAP_W'(1);
      end else begin
        gap <= gap + GAP_W'(1);
      end
    end
  end

  assert_select_tracks_busy_R2 : assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ssN);

  assert_edge_spacing_R3 : assert property (@(posedge clk) disable iff (!rstN)
    (!ssN && !prevSs && (sck != prevSck)) |-> (gap == GAP_W'(cfgDiv) + GAP_W'(1)));

  assert_edge_total_R3 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(ssN) |-> (edgeSeen == (cfgWide ? CNT_W'(2 * DATA_W) : CNT_W'(DATA_W))));

  assert_idle_level_R9 : assert property (@(posedge clk) disable iff (!rstN)
    ssN |-> (sck == cfgCpol));

  assert_rx_moves_with_done_R10 : assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> doneFlag);

  assert_done_clear_by_read_R11 : assert property (@(posedge clk) disable iff (!rstN)
    $fell(doneFlag) |-> $past(rxRead));

  assert_overrun_needs_unread_R12 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> $past(doneFlag));

endmodule

bind spi_master_engine spi_master_engine_checker #(
  .DATA_W(DATA_W),
  .DIV_W (DIV_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgCpol    (cfgCpol),
  .cfgWide    (cfgWide),
  .cfgDiv     (cfgDiv),
  .rxRead     (rxRead),
  .rxData     (rxData),
  .doneFlag   (doneFlag),
  .overrunFlag(overrunFlag),
  .busy       (busy),
  .sck        (sck),
  .ssN        (ssN)
);

// File: tb/sim_spi_master_engine.sv
`timescale 1ns/1ps
module sim_spi_master_engine;

  localparam int DATA_W = 16;
  localparam int DIV_W  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgCpol = 1'b0;
  logic              cfgCpha = 1'b0;
  logic              cfgLsbFirst = 1'b0;
  logic              cfgWide = 1'b1;
  logic [DIV_W-1:0]  cfgDiv = '0;
  logic              txWrite = 1'b0;
  logic [DATA_W-1:0] txData = '0;
  logic              statusRead = 1'b0;
  logic              rxRead = 1'b0;
  logic [DATA_W-1:0] rxData;
  logic              doneFlag;
  logic              overrunFlag;
  logic              busy;
  logic              sck;
  logic              mosi;
  logic              miso;
  logic              ssN;

  always #2 clk = ~clk;

  spi_master_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u0 (
    .clk(clk), .rstN(rstN), .cfgCpol(cfgCpol), .cfgCpha(cfgCpha),
    .cfgLsbFirst(cfgLsbFirst), .cfgWide(cfgWide), .cfgDiv(cfgDiv),
    .txWrite(txWrite), .txData(txData), .statusRead(statusRead), .rxRead(rxRead),
    .rxData(rxData), .doneFlag(doneFlag), .overrunFlag(overrunFlag), .busy(busy),
    .sck(sck), .mosi(mosi), .miso(miso), .ssN(ssN)
  );

  int vecs = 0;
  int errs = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural slave ----------------
  logic [DATA_W-1:0] slvTx = '0;
  logic [DATA_W-1:0] slvRx = '0;
  int                slvEdge = 0;
  logic              misoR = 1'b0;
  assign miso = misoR;

  function automatic int wordLen();
    return cfgWide ? DATA_W : DATA_W / 2;
  endfunction

  function automatic int bitPos(int i);
    return cfgLsbFirst ? i : wordLen() - 1 - i;
  endfunction

  always @(negedge ssN) begin
    slvEdge = 0;
    slvRx   = '0;
    if (!cfgCpha) misoR = slvTx[bitPos(0)];
  end

  always @(sck) begin
    if (ssN === 1'b0) begin
      slvEdge++;
      if (!cfgCpha) begin
        if (slvEdge % 2 == 1) slvRx[bitPos((slvEdge - 1) / 2)] = mosi;
        else if (slvEdge < 2 * wordLen()) misoR = slvTx[bitPos(slvEdge / 2)];
      end else begin
        if (slvEdge % 2 == 0) slvRx[bitPos(slvEdge / 2 - 1)] = mosi;
        else misoR = slvTx[bitPos((slvEdge - 1) / 2)];
      end
    end
  end

  // ---------------- port monitor ----------------
  logic              prevSckM = 1'b0;
  logic              prevSsM = 1'b1;
  logic              prevDoneM = 1'b0;
  int                sinceEvt = 0;
  int                edgesM = 0;
  int                minGap = 0;
  int                maxGap = 0;
  int                firstGap = -1;
  int                tailGap = -1;
  int                doneEdges = -1;
  int                nEdges = 32;
  bit                rxEarly = 1'b0;
  logic [DATA_W-1:0] rxAtStart = '0;

  always @(negedge clk) begin
    if (prevSsM && !ssN) begin
      sinceEvt = 0; edgesM = 0; minGap = 1000; maxGap = 0;
      firstGap = -1; tailGap = -1; doneEdges = -1;
      rxEarly = 1'b0; rxAtStart = rxData;
    end else if (!ssN || !prevSsM) begin
      sinceEvt++;
      if (!ssN && sck != prevSckM) begin
        edgesM++;
        if (edgesM == 1) firstGap = sinceEvt;
        if (sinceEvt < minGap) minGap = sinceEvt;
        if (sinceEvt > maxGap) maxGap = sinceEvt;
        sinceEvt = 0;
      end
      if (ssN && !prevSsM) tailGap = sinceEvt;
    end
    if (!ssN && edgesM < nEdges && rxData != rxAtStart) rxEarly = 1'b1;
    if (doneFlag && !prevDoneM) doneEdges = edgesM;
    prevSckM  = sck;
    prevSsM   = ssN;
    prevDoneM = doneFlag;
  end

  // ---------------- scenario helpers ----------------
  task automatic runXfer(string req, bit cpol, bit cpha, bit lsb, bit wide, int div,
                         logic [DATA_W-1:0] mWord, logic [DATA_W-1:0] sWord,
                         bit expectDoneRise, int midWrite);
    logic [DATA_W-1:0] mask;
    cfgCpol = cpol; cfgCpha = cpha; cfgLsbFirst = lsb; cfgWide = wide;
    cfgDiv = DIV_W'(div);
    slvTx  = sWord;
    nEdges = wide ? 2 * DATA_W : DATA_W;
    mask   = wide ? '1 : DATA_W'((1 << (DATA_W / 2)) - 1);
    @(negedge clk);
    txWrite = 1'b1; txData = mWord;
    @(negedge clk);
    txWrite = 1'b0;
    chk("R2", "select low after write", 32'(ssN), 0);
    chk("R2", "busy after write", 32'(busy), 1);
    if (!cpha && !lsb) chk("R5", "first bit on line at select", 32'(mosi), 32'(mWord[wide ? DATA_W-1 : DATA_W/2-1]));
    if (midWrite > 0) begin
      repeat (midWrite) @(negedge clk);
      txWrite = 1'b1; txData = ~mWord;
      @(negedge clk);
      txWrite = 1'b0;
    end
    while (ssN !== 1'b1) @(negedge clk);
    @(negedge clk);
    chk("R2", "lead gap", firstGap, div + 1);
    chk("R3", "edge count", edgesM, nEdges);
    chk("R3", "min half period", minGap, div + 1);
    chk("R3", "max half period", maxGap, div + 1);
    chk("R4", "tail gap", tailGap, div + 1);
    chk("R4", "sck idle after transfer", 32'(sck), 32'(cpol));
    chk("R10", "rx held during transfer", 32'(rxEarly), 0);
    if (expectDoneRise) chk("R10", "done rises on final edge", doneEdges, nEdges);
    chk(req, "slave received", 32'(slvRx), 32'(mWord & mask));
    chk(req, "master received", 32'(rxData), 32'(sWord & mask));
    chk(req, "done set", 32'(doneFlag), 1);
  endtask

  task automatic readSeq();
    @(negedge clk); statusRead = 1'b1;
    @(negedge clk); statusRead = 1'b0; rxRead = 1'b1;
    @(negedge clk); rxRead = 1'b0;
    @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "ssN", 32'(ssN), 1);
    chk("R1", "sck", 32'(sck), 0);
    chk("R1", "done", 32'(doneFlag), 0);
    chk("R1", "overrun", 32'(overrunFlag), 0);
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "rxData", 32'(rxData), 0);
    rstN = 1'b1;
    cfgCpol = 1'b1;
    @(negedge clk);
    chk("R9", "idle level high", 32'(sck), 1);
    cfgCpol = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_phase0();
    runXfer("R5", 0, 0, 0, 1, 1, 16'hA5C3, 16'h3C96, 1, 0);
    readSeq();
    chk("R5", "done cleared", 32'(doneFlag), 0);
  endtask

  task automatic t_phase1();
    runXfer("R6", 0, 1, 0, 1, 0, 16'h1E2D, 16'hF00F, 1, 0);
    readSeq();
    runXfer("R6", 0, 1, 0, 0, 2, 16'h0081, 16'h00C4, 1, 0);
    readSeq();
  endtask

  task automatic t_lsbFirst();
    runXfer("R7", 0, 0, 1, 1, 2, 16'h0001, 16'h8000, 1, 0);
    readSeq();
    runXfer("R7", 0, 1, 1, 0, 1, 16'h0035, 16'h00B2, 1, 0);
    readSeq();
  endtask

  task automatic t_narrow();
    runXfer("R8", 0, 0, 0, 0, 3, 16'hBEEF, 16'h1234, 1, 0);
    chk("R8", "upper byte zero", 32'(rxData[15:8]), 0);
    readSeq();
  endtask

  task automatic t_polarity();
    runXfer("R9", 1, 0, 0, 1, 1, 16'h5A69, 16'hC3E1, 1, 0);
    readSeq();
    runXfer("R9", 1, 1, 1, 1, 0, 16'h7711, 16'h0FF0, 1, 0);
    readSeq();
  endtask

  task automatic t_clear();
    runXfer("R11", 0, 0, 0, 1, 0, 16'h2468, 16'h1357, 1, 0);
    @(negedge clk); rxRead = 1'b1;
    @(negedge clk); rxRead = 1'b0;
    @(negedge clk);
    chk("R11", "receive read alone keeps done", 32'(doneFlag), 1);
    readSeq();
    chk("R11", "status then receive clears done", 32'(doneFlag), 0);
  endtask

  task automatic t_overrun();
    runXfer("R12", 0, 0, 0, 1, 0, 16'h1111, 16'h2222, 1, 0);
    chk("R12", "no overrun on first word", 32'(overrunFlag), 0);
    runXfer("R12", 0, 0, 0, 1, 0, 16'h3333, 16'h4444, 0, 0);
    chk("R12", "overrun set", 32'(overrunFlag), 1);
    readSeq();
    chk("R12", "done cleared", 32'(doneFlag), 0);
    chk("R12", "overrun cleared", 32'(overrunFlag), 0);
  endtask

  task automatic t_busyWrite();
    runXfer("R13", 0, 0, 0, 1, 1, 16'h6A5C, 16'h9D3B, 1, 5);
    repeat (6) @(negedge clk);
    chk("R13", "no second transfer (ssN)", 32'(ssN), 1);
    chk("R13", "no second transfer (busy)", 32'(busy), 0);
    readSeq();
  endtask

  initial begin
    t_reset();
    t_phase0();
    t_phase1();
    t_lsbFirst();
    t_narrow();
    t_polarity();
    t_clear();
    t_overrun();
    t_busyWrite();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(4 * 150000);
    vecs++;
    errs++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule